// File: doc/BRIEF.md
# Encoded Step-Number Sequencer

This block steps a machine through a fixed sequence. The active step is stored as a binary number. Each step also has a registered active flag, which is set from an equality compare against that number. A step may leave only while its own flag is set and one of its exit conditions is true. Every step therefore lasts at least two clocks: one for the flag to catch up with the new number, and one in which the exit can fire. Exit conditions are sampled as levels, not edges. A condition that is already true when a step is entered still moves the sequence on at the first cycle the step is eligible.

The actuator outputs come only from the active flags. An emergency stop sends the sequence back to the idle step from any step. Pause freezes the step number, so running resumes on the same step, and it also holds the pump off. The valve is not affected by pause.

The steps are IDLE (0), GRIP (1), WELD (2), COOL (3), INSPECT (4), RELEASE (5), EJECT (6) and REJECT (7). The transitions are:

- IDLE→GRIP on `start_i`
- GRIP→WELD on `cond_i[0]`
- WELD→COOL on `cond_i[1]`
- WELD→REJECT on `cond_i[2]`
- COOL→INSPECT on `cond_i[3]`
- INSPECT→RELEASE on `cond_i[4]`
- RELEASE→EJECT on `cond_i[5]`
- EJECT→IDLE on `cond_i[6]`
- REJECT→IDLE on `cond_i[7]`

Top module: `stepseq`

## Requirements
- R1: While `rst_n` is low, `step_o` is 0, `step_active_o` is all zeros, and `valve_o` and `pump_o` are low.
- R2: One clock edge after `step_o` holds value k, `step_active_o` has exactly bit k set and no other bit set. At most one bit of `step_active_o` is ever set.
- R3: `step_o` takes a new value by a transition only on a clock edge at which `step_active_o[step_o]` is set, so each step lasts at least two clock edges.
- R4: Exit conditions are sampled as levels. A condition held true from the moment a step is entered advances the step on the second edge after entry.
- R5: Transitions follow this table:
  - 0→1 on `start_i`
  - 1→2 on `cond_i[0]`
  - 2→3 on `cond_i[1]`
  - 2→7 on `cond_i[2]`
  - 3→4 on `cond_i[3]`
  - 4→5 on `cond_i[4]`
  - 5→6 on `cond_i[5]`
  - 6→0 on `cond_i[6]`
  - 7→0 on `cond_i[7]`

  A condition bit that does not belong to the current step has no effect.
- R6: In step 2, when `cond_i[1]` and `cond_i[2]` are both true, the sequence moves to step 3, the lower-numbered target.
- R7: When `estop_i` is high at a clock edge, `step_o` becomes 0 at that edge. This overrides pause and every transition.
- R8: While `pause_i` is high (and `estop_i` is low), `step_o` holds its value and `pump_o` is low. `valve_o` is unaffected by pause.
- R9: `valve_o` equals the OR of `step_active_o` bits 1, 2 and 3. `pump_o` equals bit 2 AND NOT `pause_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition for leaving idle |
| cond_i | input | 8 | Exit conditions, one per non-idle step |
| pause_i | input | 1 | Freeze step and gate pump |
| estop_i | input | 1 | Emergency stop, forces idle |
| step_o | output | 3 | Current step number |
| step_active_o | output | 8 | Registered one-hot step-active flags |
| valve_o | output | 1 | Valve drive |
| pump_o | output | 1 | Pump drive |

## Verification
The bench holds exit conditions true before and across each step entry. A design that detected edges would then stall, and one that advanced on the number alone would pass through a step in a single clock. It drives both WELD exits together to catch a wrong priority, and it asserts pause and emergency stop in the same cycle to confirm that the stop wins. It also drives condition bits that belong to other steps, which a loosely decoded table would act on. Finally, it checks that the pump drops under pause while the valve stays on, and that the flags settle one edge behind the step number.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
    localparam int NUM_STEPS = 8;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int NUM_COND  = 8;

    typedef enum logic [STEP_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_GRIP    = 3'd1,
        ST_WELD    = 3'd2,
        ST_COOL    = 3'd3,
        ST_INSPECT = 3'd4,
        ST_RELEASE = 3'd5,
        ST_EJECT   = 3'd6,
        ST_REJECT  = 3'd7
    } step_e;

    localparam int C_GRIPPED   = 0;
    localparam int C_WELD_OK   = 1;
    localparam int C_WELD_BAD  = 2;
    localparam int C_COOLED    = 3;
    localparam int C_INSPECTED = 4;
    localparam int C_RELEASED  = 5;
    localparam int C_EJECTED   = 6;
    localparam int C_REJECTED  = 7;

    localparam logic [NUM_STEPS-1:0] VALVE_MASK =
        NUM_STEPS'((1 << ST_GRIP) | (1 << ST_WELD) | (1 << ST_COOL));
    localparam logic [NUM_STEPS-1:0] PUMP_MASK =
        NUM_STEPS'(1 << ST_WELD);
endpackage

// File: rtl/stepseq_decode.sv
module stepseq_decode
    import stepseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STEP_W-1:0]    step_i,
    output logic [NUM_STEPS-1:0] active_o
);
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active_o[g] <= 1'b0;
            end else begin
                active_o[g] <= (step_i == STEP_W'(g));
            end
        end
    end

    // R2
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_o));
endmodule

// File: rtl/stepseq_next.sv
module stepseq_next
    import stepseq_pkg::*;
(
    input  step_e                step_i,
    input  logic                 eligible_i,
    input  logic                 start_i,
    input  logic [NUM_COND-1:0]  cond_i,
    output logic                 adv_o,
    output step_e                nxt_o
);
    step_e target;
    logic  fire;

    always_comb begin
        target = step_i;
        fire   = 1'b0;
        unique case (step_i)
            ST_IDLE: begin
                fire   = start_i;
                target = ST_GRIP;
            end
            ST_GRIP: begin
                fire   = cond_i[C_GRIPPED];
                target = ST_WELD;
            end
            ST_WELD: begin
                if (cond_i[C_WELD_OK]) begin
                    fire   = 1'b1;
                    target = ST_COOL;
                end else if (cond_i[C_WELD_BAD]) begin
                    fire   = 1'b1;
                    target = ST_REJECT;
                end
            end
            ST_COOL: begin
                fire   = cond_i[C_COOLED];
                target = ST_INSPECT;
            end
            ST_INSPECT: begin
                fire   = cond_i[C_INSPECTED];
                target = ST_RELEASE;
            end
            ST_RELEASE: begin
                fire   = cond_i[C_RELEASED];
                target = ST_EJECT;
            end
            ST_EJECT: begin
                fire   = cond_i[C_EJECTED];
                target = ST_IDLE;
            end
            ST_REJECT: begin
                fire   = cond_i[C_REJECTED];
                target = ST_IDLE;
            end
            default: begin
                fire   = 1'b0;
                target = ST_IDLE;
            end
        endcase
    end

    assign adv_o = fire & eligible_i;
    assign nxt_o = target;
endmodule

// File: rtl/stepseq_drive.sv
module stepseq_drive
    import stepseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_STEPS-1:0] active_i,
    input  logic                 pause_i,
    output logic                 valve_o,
    output logic                 pump_o
);
    always_comb begin
        valve_o = |(active_i & VALVE_MASK);
        pump_o  = (|(active_i & PUMP_MASK)) & ~pause_i;
    end

    // R8
    pump_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |-> !pump_o);
endmodule

// File: rtl/stepseq.sv
module stepseq
    import stepseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_COND-1:0]  cond_i,
    input  logic                 pause_i,
    input  logic                 estop_i,
    output logic [STEP_W-1:0]    step_o,
    output logic [NUM_STEPS-1:0] step_active_o,
    output logic                 valve_o,
    output logic                 pump_o
);
    step_e                step_q;
    step_e                step_nxt;
    logic                 adv;
    logic                 cur_active;
    logic [NUM_STEPS-1:0] active;

    assign cur_active = active[step_q];

    stepseq_next u_next (
        .step_i     (step_q),
        .eligible_i (cur_active),
        .start_i    (start_i),
        .cond_i     (cond_i),
        .adv_o      (adv),
        .nxt_o      (step_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else if (estop_i) begin
            step_q <= ST_IDLE;
        end else if (pause_i) begin
            step_q <= step_q;
        end else if (adv) begin
            step_q <= step_nxt;
        end
    end

    stepseq_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step_q),
        .active_o (active)
    );

    stepseq_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .pause_i  (pause_i),
        .valve_o  (valve_o),
        .pump_o   (pump_o)
    );

    assign step_o        = step_q;
    assign step_active_o = active;

    // R7
    estop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        estop_i |=> (step_q == ST_IDLE));

    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && !estop_i) |=> $stable(step_q));

    // R3
    dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(estop_i) && (step_q != $past(step_q))) |-> $past(cur_active));
endmodule

// File: tb/stepseq_bench.sv
module stepseq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] cond_i = 8'h00;
    logic       pause_i = 1'b0;
    logic       estop_i = 1'b0;
    logic [2:0] step_o;
    logic [7:0] step_active_o;
    logic       valve_o;
    logic       pump_o;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepseq u_stepseq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cond_i        (cond_i),
        .pause_i       (pause_i),
        .estop_i       (estop_i),
        .step_o        (step_o),
        .step_active_o (step_active_o),
        .valve_o       (valve_o),
        .pump_o        (pump_o)
    );

    // {start, pause, estop, cond[7:0], expected step after the edge}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 8'h00, 3'd0},  // R3 idle flag not yet set
        {1'b1, 1'b0, 1'b0, 8'h00, 3'd1},  // R5 idle->grip
        {1'b0, 1'b0, 1'b0, 8'h01, 3'd1},  // R4 dwell with cond held
        {1'b0, 1'b0, 1'b0, 8'h01, 3'd2},  // R4 level advance
        {1'b0, 1'b0, 1'b0, 8'h06, 3'd2},  // R3 dwell
        {1'b0, 1'b0, 1'b0, 8'h06, 3'd3},  // R6 lower target wins
        {1'b0, 1'b0, 1'b0, 8'h08, 3'd3},
        {1'b0, 1'b0, 1'b0, 8'h08, 3'd4},  // R5 cool->inspect
        {1'b0, 1'b0, 1'b0, 8'h00, 3'd4},
        {1'b0, 1'b0, 1'b0, 8'h00, 3'd4},
        {1'b0, 1'b1, 1'b0, 8'h10, 3'd4},  // R8 pause holds
        {1'b0, 1'b0, 1'b0, 8'h10, 3'd5},  // R8 resume same step
        {1'b0, 1'b0, 1'b1, 8'h20, 3'd0}   // R7 estop
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go(input logic s, input logic [7:0] c, input logic p, input logic e);
        start_i = s;
        cond_i  = c;
        pause_i = p;
        estop_i = e;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 step", int'(step_o), 0);
        check("R1 flags", int'(step_active_o), 0);
        check("R1 valve", int'(valve_o), 0);
        check("R1 pump", int'(pump_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            go(VEC[i][13], VEC[i][10:3], VEC[i][12], VEC[i][11]);
            check($sformatf("table row %0d (R3/R4/R5/R6/R7/R8)", i),
                  int'(step_o), int'(VEC[i][2:0]));
        end

        // reject branch, pause on outputs
        go(1'b1, 8'h00, 1'b0, 1'b0);
        go(1'b1, 8'h00, 1'b0, 1'b0);
        go(1'b0, 8'h01, 1'b0, 1'b0);
        go(1'b0, 8'h01, 1'b0, 1'b0);
        check("R5 grip->weld", int'(step_o), 2);
        check("R9 valve from grip flag", int'(valve_o), 1);
        check("R9 pump off outside weld", int'(pump_o), 0);
        go(1'b0, 8'h04, 1'b0, 1'b0);
        check("R9 pump in weld", int'(pump_o), 1);
        check("R9 valve in weld", int'(valve_o), 1);
        go(1'b0, 8'h04, 1'b1, 1'b0);
        check("R8 step held", int'(step_o), 2);
        check("R8 pump gated", int'(pump_o), 0);
        check("R8 valve kept", int'(valve_o), 1);
        go(1'b0, 8'h04, 1'b0, 1'b0);
        check("R5 weld->reject", int'(step_o), 7);
        go(1'b0, 8'h01, 1'b0, 1'b0);
        check("R5 foreign cond ignored", int'(step_o), 7);
        check("R9 valve off in reject", int'(valve_o), 0);
        go(1'b0, 8'h7F, 1'b0, 1'b0);
        check("R5 foreign conds ignored", int'(step_o), 7);
        go(1'b0, 8'h80, 1'b0, 1'b0);
        check("R5 reject->idle", int'(step_o), 0);

        // estop beats pause
        go(1'b1, 8'h00, 1'b0, 1'b0);
        go(1'b1, 8'h00, 1'b0, 1'b0);
        go(1'b0, 8'h01, 1'b0, 1'b0);
        go(1'b0, 8'h01, 1'b0, 1'b0);
        go(1'b0, 8'h06, 1'b1, 1'b1);
        check("R7 estop over pause", int'(step_o), 0);
        go(1'b0, 8'h00, 1'b0, 1'b0);
        check("R2 idle flag only", int'(step_active_o), 1);

        // reset mid-run
        go(1'b1, 8'h00, 1'b0, 1'b0);
        check("R5 idle->grip again", int'(step_o), 1);
        rst_n = 1'b0;
        #1;
        check("R1 reset step", int'(step_o), 0);
        check("R1 reset flags", int'(step_active_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule